// File: doc/BRIEF.md
# PLL Drift Recalibration Controller

This block supervises a phase-locked loop after it has locked. At the moment the loop reports lock, the block records the die temperature from a signed 8-bit sensor reading and keeps it as the drift reference. While the loop stays locked, the block compares each new reading against that reference. When the absolute difference exceeds a programmable limit, it raises a recalibration flag. A reference captured below zero degrees gets a wider limit, because cold locks tolerate more drift.

Two recalibration policies are available. The manual policy is selected after reset: the flag stays set until software issues a relock command. The automatic policy starts the relock by itself as soon as the flag is raised. Every relock that starts from the locked state, including one caused by a new multiplier or divider setting, first raises a memory stall for one cycle. It then switches the loop output to bypass and holds both signals until the analog lock-done pulse arrives. If the lock takes unusually long, a slow-lock indication is raised, but the controller keeps waiting. Voltage sensing is not modelled.

Top module: `pll_drift_recal`

## Requirements
- R1: After reset the controller is off: pll_bypass, mem_stall, pll_locked, recal_flag and lock_slow are all 0. The policy is manual and the drift limit is 55.
- R2: Raising pll_en while off enters the lock wait, with pll_bypass=1 and mem_stall=0. A lock_done pulse sampled there makes pll_locked=1 and pll_bypass=0 on the next cycle.
- R3: While locked, recal_flag rises one cycle after |temp_in - reference| becomes strictly greater than the limit, for drift in either direction. A drift equal to the limit raises no flag.
- R4: Every lock sets the reference to the temp_in value sampled together with lock_done.
- R5: recal_flag is 0 whenever pll_locked is 0, whatever the temperature, including in the off, bypass and lock-wait states.
- R6: In the manual policy, a raised flag stays set while the loop stays locked and out of bypass, even after the temperature returns. relock_cmd clears the flag and starts a relock.
- R7: In the automatic policy, the cycle after recal_flag rises, the controller clears the flag and starts a relock without any command.
- R8: A relock from the locked state raises mem_stall one cycle before pll_bypass. mem_stall stays high through the lock wait and falls in the same cycle that pll_locked rises.
- R9: When the captured reference is negative, the effective limit is the programmed limit plus COLD_EXTRA (default 10).
- R10: A cfg_we pulse loads cfg_lim as the drift limit and cfg_auto as the policy (1 = automatic).
- R11: The lock wait is left only on lock_done (or on pll_en low). lock_slow rises once LOCK_TMO cycles have passed in the wait, and the controller stays in the wait.
- R12: cfg_upd (new multiplier or divider) while locked starts a relock with the same stall and bypass sequence.
- R13: byp_req while locked enters bypass (pll_bypass=1, mem_stall=0, flag cleared). Releasing byp_req enters the lock wait without a stall. pll_en low returns to off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_en | input | 1 | Loop enable; low forces the off state |
| byp_req | input | 1 | Software bypass request |
| cfg_upd | input | 1 | Pulse: new multiplier or divider written |
| relock_cmd | input | 1 | Pulse: software relock command |
| lock_done | input | 1 | Pulse from the analog lock detector |
| temp_in | input | 8 | Signed temperature in degrees |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_auto | input | 1 | Policy written on cfg_we (1 = automatic) |
| cfg_lim | input | 8 | Drift limit written on cfg_we (unsigned degrees) |
| recal_flag | output | 1 | Drift beyond the limit detected while locked |
| pll_bypass | output | 1 | Loop output in bypass |
| mem_stall | output | 1 | Memory controller must hold accesses |
| pll_locked | output | 1 | Loop is in the locked state |
| lock_slow | output | 1 | Lock wait exceeded LOCK_TMO cycles |

## Verification
Drift detection is exercised with rising and falling temperatures, at exactly the limit and one degree past it. This separates a strict comparison from an inclusive one, and a signed magnitude from a one-sided difference. Relocking at a new temperature and then moving back shows that the reference is replaced, not retained. Cold locks, a lowered programmed limit and both policies show which limit and which reaction apply. Bypass, off and lock-wait phases with extreme temperatures confirm that the flag is suppressed away from lock, and the stall and bypass edges are sampled cycle by cycle around each relock.

// File: rtl/pll_recal_pkg.sv
package pll_recal_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_BYPASS  = 3'd1,
    ST_LOCKING = 3'd2,
    ST_LOCKED  = 3'd3,
    ST_RECAL   = 3'd4
  } pll_st_e;
endpackage

// File: rtl/pll_drift_mon.sv
module pll_drift_mon #(
  parameter int TEMP_W     = 8,
  parameter int LIM_RST    = 55,
  parameter int COLD_EXTRA = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [TEMP_W-1:0] temp_in,
  input  logic              cfg_we,
  input  logic [TEMP_W-1:0] cfg_lim,
  output logic              exceed
);
  localparam int DW = TEMP_W + 1;

  logic [TEMP_W-1:0] ref_q, lim_q;
  logic              cold_q;
  logic signed [DW-1:0] diff;
  logic [DW-1:0] mag, eff_lim;

  // reference capture, enabled only on a lock event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      cold_q <= 1'b0;
    end else if (cap_en) begin
      ref_q  <= temp_in;
      cold_q <= temp_in[TEMP_W-1];
    end
  end

  // programmable drift limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lim_q <= TEMP_W'(LIM_RST);
    else if (cfg_we) lim_q <= cfg_lim;
  end

  always_comb begin
    diff    = $signed({temp_in[TEMP_W-1], temp_in}) - $signed({ref_q[TEMP_W-1], ref_q});
    mag     = diff[DW-1] ? DW'(-diff) : DW'(diff);
    eff_lim = {1'b0, lim_q} + (cold_q ? DW'(COLD_EXTRA) : DW'(0));
    exceed  = (mag > eff_lim);
  end
endmodule

// File: rtl/pll_recal_fsm.sv
module pll_recal_fsm
  import pll_recal_pkg::*;
#(
  parameter int LOCK_TMO = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pll_en,
  input  logic    byp_req,
  input  logic    cfg_upd,
  input  logic    relock_cmd,
  input  logic    lock_done,
  input  logic    cfg_we,
  input  logic    cfg_auto,
  input  logic    exceed,
  output pll_st_e state,
  output logic    auto_mode,
  output logic    cap_en,
  output logic    recal_flag,
  output logic    pll_bypass,
  output logic    mem_stall,
  output logic    pll_locked,
  output logic    lock_slow
);
  localparam int CNT_W = $clog2(LOCK_TMO + 1);

  pll_st_e    st_q, st_d;
  logic       flag_q, flag_d, stall_q, stall_d, auto_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:     if (pll_en) st_d = ST_LOCKING;
      ST_BYPASS:  if (!pll_en) st_d = ST_OFF;
                  else if (!byp_req) st_d = ST_LOCKING;
      ST_LOCKING: if (!pll_en) st_d = ST_OFF;
                  else if (lock_done) st_d = ST_LOCKED;
      ST_LOCKED:  if (!pll_en) st_d = ST_OFF;
                  else if (byp_req) st_d = ST_BYPASS;
                  else if (cfg_upd || relock_cmd || (flag_q && auto_q)) st_d = ST_RECAL;
      ST_RECAL:   st_d = pll_en ? ST_LOCKING : ST_OFF;
      default:    st_d = ST_OFF;
    endcase
  end

  always_comb begin
    flag_d  = (st_q == ST_LOCKED) && (st_d == ST_LOCKED) && (flag_q || exceed);
    stall_d = (st_d == ST_RECAL) || (stall_q && (st_d == ST_LOCKING));
    cnt_d   = '0;
    if (st_q == ST_LOCKING && st_d == ST_LOCKING)
      cnt_d = (cnt_q == CNT_W'(LOCK_TMO)) ? cnt_q : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      flag_q  <= 1'b0;
      stall_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      st_q    <= st_d;
      flag_q  <= flag_d;
      stall_q <= stall_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) auto_q <= 1'b0;
    else if (cfg_we) auto_q <= cfg_auto;
  end

  assign state      = st_q;
  assign auto_mode  = auto_q;
  assign cap_en     = (st_q == ST_LOCKING) && (st_d == ST_LOCKED);
  assign recal_flag = flag_q;
  assign mem_stall  = stall_q;
  assign pll_bypass = (st_q == ST_BYPASS) || (st_q == ST_LOCKING);
  assign pll_locked = (st_q == ST_LOCKED);
  assign lock_slow  = (st_q == ST_LOCKING) && (cnt_q == CNT_W'(LOCK_TMO));
endmodule

// File: rtl/pll_drift_recal.sv
module pll_drift_recal
  import pll_recal_pkg::*;
#(
  parameter int TEMP_W     = 8,
  parameter int LIM_RST    = 55,
  parameter int COLD_EXTRA = 10,
  parameter int LOCK_TMO   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pll_en,
  input  logic              byp_req,
  input  logic              cfg_upd,
  input  logic              relock_cmd,
  input  logic              lock_done,
  input  logic [TEMP_W-1:0] temp_in,
  input  logic              cfg_we,
  input  logic              cfg_auto,
  input  logic [TEMP_W-1:0] cfg_lim,
  output logic              recal_flag,
  output logic              pll_bypass,
  output logic              mem_stall,
  output logic              pll_locked,
  output logic              lock_slow
);
  pll_st_e st_w;
  logic    auto_w, cap_w, exceed_w;

  pll_drift_mon #(
    .TEMP_W(TEMP_W), .LIM_RST(LIM_RST), .COLD_EXTRA(COLD_EXTRA)
  ) u_mon (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_w), .temp_in(temp_in),
    .cfg_we(cfg_we), .cfg_lim(cfg_lim), .exceed(exceed_w)
  );

  pll_recal_fsm #(.LOCK_TMO(LOCK_TMO)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pll_en(pll_en), .byp_req(byp_req),
    .cfg_upd(cfg_upd), .relock_cmd(relock_cmd), .lock_done(lock_done),
    .cfg_we(cfg_we), .cfg_auto(cfg_auto), .exceed(exceed_w),
    .state(st_w), .auto_mode(auto_w), .cap_en(cap_w),
    .recal_flag(recal_flag), .pll_bypass(pll_bypass), .mem_stall(mem_stall),
    .pll_locked(pll_locked), .lock_slow(lock_slow)
  );
endmodule

// File: rtl/pll_recal_chk.sv
module pll_recal_chk
  import pll_recal_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    pll_en,
  input logic    byp_req,
  input logic    cfg_upd,
  input logic    relock_cmd,
  input logic    lock_done,
  input pll_st_e state,
  input logic    auto_mode,
  input logic    recal_flag,
  input logic    pll_bypass,
  input logic    mem_stall,
  input logic    pll_locked
);
  // R5: flag only while locked
  p_flag_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    recal_flag |-> pll_locked);

  // R8: stall leads bypass by one cycle
  p_stall_lead_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_stall && !pll_bypass && pll_en) |=> pll_bypass);

  // R8: stall released together with lock
  p_stall_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOCKING && mem_stall && lock_done && pll_en) |=> (!mem_stall && pll_locked));

  // R11: lock wait left only on lock_done
  p_lock_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOCKING && pll_en && !lock_done) |=> (state == ST_LOCKING));

  // R6: manual flag sticky
  p_manual_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (recal_flag && !auto_mode && pll_en && !byp_req && !cfg_upd && !relock_cmd)
      |=> recal_flag);

  // R7: automatic policy reacts to the flag
  p_auto_relock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (recal_flag && auto_mode && pll_en && !byp_req) |=> (mem_stall && !recal_flag));
endmodule

bind pll_drift_recal pll_recal_chk i_chk (
  .clk(clk), .rst_n(rst_n), .pll_en(pll_en), .byp_req(byp_req),
  .cfg_upd(cfg_upd), .relock_cmd(relock_cmd), .lock_done(lock_done),
  .state(st_w), .auto_mode(auto_w), .recal_flag(recal_flag),
  .pll_bypass(pll_bypass), .mem_stall(mem_stall), .pll_locked(pll_locked)
);

// File: tb/test_pll_drift_recal.sv
module test_pll_drift_recal;
  localparam int TMO = 8;

  logic clk, rst_n, pll_en, byp_req, cfg_upd, relock_cmd, lock_done;
  logic cfg_we, cfg_auto;
  logic [7:0] temp_in, cfg_lim;
  logic recal_flag, pll_bypass, mem_stall, pll_locked, lock_slow;
  int n_chk, n_bad;
  bit done;

  pll_drift_recal #(.LOCK_TMO(TMO)) i_pll_drift_recal (
    .clk(clk), .rst_n(rst_n), .pll_en(pll_en), .byp_req(byp_req),
    .cfg_upd(cfg_upd), .relock_cmd(relock_cmd), .lock_done(lock_done),
    .temp_in(temp_in), .cfg_we(cfg_we), .cfg_auto(cfg_auto), .cfg_lim(cfg_lim),
    .recal_flag(recal_flag), .pll_bypass(pll_bypass), .mem_stall(mem_stall),
    .pll_locked(pll_locked), .lock_slow(lock_slow)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // outputs {flag, bypass, stall, locked}
  task automatic chk4(input string tag, input logic f, b, s, l);
    chk({tag, " flag"},   recal_flag, f);
    chk({tag, " bypass"}, pll_bypass, b);
    chk({tag, " stall"},  mem_stall,  s);
    chk({tag, " locked"}, pll_locked, l);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pll_en = 0; byp_req = 0; cfg_upd = 0; relock_cmd = 0;
    lock_done = 0; cfg_we = 0; cfg_auto = 0; cfg_lim = 0; temp_in = 0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic lock_at(input logic signed [7:0] t);
    pll_en = 1'b1;
    step(1);
    temp_in = t; lock_done = 1'b1;
    step(1);
    lock_done = 1'b0;
  endtask

  task automatic t_reset_and_lock();
    do_reset();
    chk4("R1 reset", 0, 0, 0, 0);
    chk("R1 reset slow", lock_slow, 0);
    pll_en = 1'b1;
    step(1);
    chk4("R2 lock wait", 0, 1, 0, 0);
    temp_in = 8'sd25; lock_done = 1'b1;
    step(1);
    lock_done = 1'b0;
    chk4("R2 locked", 0, 0, 0, 1);
    temp_in = 8'sd80; step(1);
    chk("R1 default limit 55 equal drift", recal_flag, 0);
    temp_in = 8'sd81; step(1);
    chk("R3 rising drift past limit", recal_flag, 1);
    chk("R6 manual no bypass", pll_bypass, 0);
  endtask

  task automatic t_manual_relock();
    temp_in = 8'sd25; step(3);
    chk("R6 flag sticky", recal_flag, 1);
    relock_cmd = 1'b1; step(1); relock_cmd = 1'b0;
    chk4("R8 stall before bypass", 0, 0, 1, 0);
    step(1);
    chk4("R8 bypass with stall", 0, 1, 1, 0);
    step(2);
    chk("R8 stall held in wait", mem_stall, 1);
    temp_in = 8'sd81; lock_done = 1'b1; step(1); lock_done = 1'b0;
    chk4("R8 stall released at lock", 0, 0, 0, 1);
    temp_in = 8'sd26; step(1);
    chk("R4 new reference equal drift", recal_flag, 0);
    temp_in = 8'sd25; step(1);
    chk("R4 R3 falling drift past limit", recal_flag, 1);
  endtask

  task automatic t_auto();
    do_reset();
    cfg_we = 1'b1; cfg_auto = 1'b1; cfg_lim = 8'd20; step(1); cfg_we = 1'b0;
    lock_at(8'sd0);
    temp_in = 8'sd20; step(1);
    chk("R10 programmed limit equal", recal_flag, 0);
    temp_in = -8'sd21; step(1);
    chk4("R7 R10 auto flag", 1, 0, 0, 1);
    step(1);
    chk4("R7 auto relock stall", 0, 0, 1, 0);
    step(1);
    chk4("R7 auto relock bypass", 0, 1, 1, 0);
    lock_done = 1'b1; step(1); lock_done = 1'b0;
    chk4("R7 relocked", 0, 0, 0, 1);
    step(1);
    chk("R4 auto relock at -21 no flag", recal_flag, 0);
  endtask

  task automatic t_cold();
    do_reset();
    lock_at(-8'sd10);
    temp_in = 8'sd55; step(1);
    chk("R9 cold limit 65 equal", recal_flag, 0);
    temp_in = 8'sd56; step(1);
    chk("R9 cold limit exceeded", recal_flag, 1);
  endtask

  task automatic t_suppress();
    do_reset();
    temp_in = 8'sd127; pll_en = 1'b1; step(3);
    chk4("R5 no flag in lock wait", 0, 1, 0, 0);
    temp_in = 8'sd0; lock_done = 1'b1; step(1); lock_done = 1'b0;
    byp_req = 1'b1; step(1);
    chk4("R13 bypass entered", 0, 1, 0, 0);
    temp_in = -8'sd128; step(3);
    chk("R5 no flag in bypass", recal_flag, 0);
    byp_req = 1'b0; temp_in = 8'sd0; step(1);
    chk4("R13 bypass release no stall", 0, 1, 0, 0);
    lock_done = 1'b1; step(1); lock_done = 1'b0;
    temp_in = 8'sd100; step(1);
    chk("R5 flag when locked", recal_flag, 1);
    byp_req = 1'b1; step(1); byp_req = 1'b0;
    chk4("R13 flag cleared in bypass", 0, 1, 0, 0);
    pll_en = 1'b0; step(2);
    chk4("R13 R5 off", 0, 0, 0, 0);
  endtask

  task automatic t_timeout_and_update();
    do_reset();
    pll_en = 1'b1; step(1);
    step(TMO - 1);
    chk("R11 slow not yet", lock_slow, 0);
    step(1);
    chk("R11 slow after timeout", lock_slow, 1);
    step(3);
    chk4("R11 still waiting", 0, 1, 0, 0);
    lock_done = 1'b1; step(1); lock_done = 1'b0;
    chk("R11 locked after slow", pll_locked, 1);
    chk("R11 slow cleared", lock_slow, 0);
    cfg_upd = 1'b1; step(1); cfg_upd = 1'b0;
    chk4("R12 update stall", 0, 0, 1, 0);
    step(1);
    chk4("R12 update bypass", 0, 1, 1, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    t_reset_and_lock();
    t_manual_relock();
    t_auto();
    t_cold();
    t_suppress();
    t_timeout_and_update();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule